// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power state of a multi-core processor and tells the rest of the chip which clocks may run. It watches the per-core halt indications, a stop-clock request from the platform, a chain of three sleep-depth requests, bus snoop strobes, the four break events and a re-initialization request. From these it walks a single state machine through the halt states, the stop-grant states, their snoop variants and the three sleep depths. It only reports the request for a lower frequency and voltage operating point; it does not carry out that change.

Two timed waits are built in. Stop-grant entry happens a fixed number of bus clocks after the acknowledge response strobe. Returning from the deepest clock-stopped depths to Sleep needs a stabilization wait whose length in cycles is a parameter. Break events that arrive while clocks are stopped for a stop grant are remembered, one bit per kind, and handed to the core as a one-cycle pulse when the controller is back in Normal. Pin sequences that the platform must not produce are recorded in a sticky error flag, and the controller does not move on them.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After rst_n low, state_o is Normal (0), core_clk_en is 1, bus_clk_may_stop is 0, err_flag is 0 and evt_deliver is 0.
- R2: In Normal with stop_req low, the state becomes HALT (1) one cycle after every core_halt bit is 1, or Extended HALT (2) if ext_halt_en is 1; with only some bits set it stays Normal.
- R3: In HALT or Extended HALT any of brk_mgmt, brk_init, brk_nmi, brk_intr moves the state to Normal on the next cycle.
- R4: stop_req high in Normal or a halt state moves to the acknowledge-wait state (5); the state becomes Stop Grant (6), or Extended Stop Grant (7) if ext_stop_en is 1, exactly STOP_DELAY cycles after the clock edge that samples sg_ack_resp; stop_req low before then returns to where the wait started.
- R5: stop_req low in Stop Grant or Extended Stop Grant returns to the state held before the stop request (Normal, HALT or Extended HALT), except that it returns to Normal when any break event is pending.
- R6: Break events seen in the stop-grant states and their snoop variants are latched, one bit per kind (bit 0 brk_mgmt, bit 1 brk_init, bit 2 brk_nmi, bit 3 brk_intr), and appear on evt_deliver for exactly one cycle, in the first cycle back in Normal, each at most once however often it arrived.
- R7: reinit_req clears all pending events; in the stop-grant states and their snoop variants it does not change the state, in every other state it moves to Normal on the next cycle.
- R8: snoop_start in HALT (1), Extended HALT (2), Stop Grant (6) or Extended Stop Grant (7) moves to the matching snoop state (3, 4, 8, 9); snoop_done there returns to the exact state that was left.
- R9: A rising edge of sleep_req in a stop-grant state enters Sleep (10), a rising edge of deep_req in Sleep enters Deep Sleep (12), a rising edge of deeper_req in Deep Sleep enters Deeper Sleep (13); deeper_req low returns to Deep Sleep and sleep_req low in Sleep returns to the stop-grant state Sleep was entered from.
- R10: deep_req low in Deep Sleep enters the stabilization state (11), which lasts exactly WAKE_CYCLES cycles before the state becomes Sleep.
- R11: In Sleep, stabilization, Deep Sleep and Deeper Sleep break events are neither serviced nor latched, and reinit_req moves straight to Normal.
- R12: A rising edge of sleep_req outside the two stop-grant states, of deep_req outside Sleep, of deeper_req outside Deep Sleep, or snoop_start in any of states 10 to 13 sets err_flag, which stays set until rst_n; the state does not change on that stimulus.
- R13: core_clk_en is 1 only in states 0, 3, 4, 5, 8, 9; bus_clk_may_stop only in 12 and 13; snoop_ok in all states but 10 to 13; low_op_req only in 2, 4, 7, 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| core_halt | input | NCORES | Per-core halted indication |
| ext_halt_en | input | 1 | Select Extended HALT instead of HALT |
| ext_stop_en | input | 1 | Select Extended Stop Grant instead of Stop Grant |
| stop_req | input | 1 | Stop-clock request from the platform, active high |
| sleep_req | input | 1 | Sleep request, active high |
| deep_req | input | 1 | Deep Sleep request, active high |
| deeper_req | input | 1 | Deeper Sleep request, active high |
| snoop_start | input | 1 | Strobe: a bus snoop has been detected |
| snoop_done | input | 1 | Strobe: the snoop has been serviced |
| brk_mgmt | input | 1 | System-management break event |
| brk_init | input | 1 | Init break event |
| brk_nmi | input | 1 | Non-maskable interrupt break event |
| brk_intr | input | 1 | Maskable interrupt break event |
| reinit_req | input | 1 | Processor re-initialization request |
| sg_ack_resp | input | 1 | Strobe: response phase of the stop-grant acknowledge |
| state_o | output | 4 | Current state code |
| core_clk_en | output | 1 | Internal core clock enable |
| bus_clk_may_stop | output | 1 | Platform may stop the bus clock |
| snoop_ok | output | 1 | Snoops may be serviced |
| low_op_req | output | 1 | Request for the lower frequency and voltage point |
| evt_deliver | output | 4 | One-cycle pulse of pending break events |
| err_flag | output | 1 | Sticky illegal-sequence flag |

## Verification
The halt path is driven with a partial and a full core mask and with both values of the extended enable, which separates the all-cores rule from a single-core trigger and the two halt flavours. Stop grant is entered from Normal and from HALT, left with and without pending events, and aborted before the acknowledge, so a wrong origin register, an off-by-one delay or a lost or repeated event each give a different state or pulse. The sleep chain is walked down and back up with interrupts and snoops thrown in, telling apart an exact stabilization count, a latch that wrongly records events in sleep, and an error flag that fires on legal steps or misses illegal ones.

// File: rtl/pwr_pkg.sv
// Shared state codes and state-class helpers for the low-power controller.
// Assumes: codes are visible at the top-level state_o port and must not move.
package pwr_pkg;

    typedef enum logic [3:0] {
        ST_NORMAL    = 4'd0,
        ST_HALT      = 4'd1,
        ST_EHALT     = 4'd2,
        ST_HALT_SNP  = 4'd3,
        ST_EHALT_SNP = 4'd4,
        ST_SG_PEND   = 4'd5,
        ST_SG        = 4'd6,
        ST_ESG       = 4'd7,
        ST_SG_SNP    = 4'd8,
        ST_ESG_SNP   = 4'd9,
        ST_SLEEP     = 4'd10,
        ST_WAKE      = 4'd11,
        ST_DEEP      = 4'd12,
        ST_DEEPER    = 4'd13
    } pwr_state_e;

    // Number of break-event kinds tracked by the pending latch.
    localparam int unsigned NUM_BRK = 4;

    // True in the states where all internal clocks are stopped.
    function automatic logic in_sleep_fam(pwr_state_e s);
        return (s == ST_SLEEP) || (s == ST_WAKE) || (s == ST_DEEP) || (s == ST_DEEPER);
    endfunction

    // True in the stop-grant states and their snoop variants.
    function automatic logic in_sg_fam(pwr_state_e s);
        return (s == ST_SG) || (s == ST_ESG) || (s == ST_SG_SNP) || (s == ST_ESG_SNP);
    endfunction

endpackage

// File: rtl/pwr_edge_det.sv
// Rising-edge detector for a bank of level request pins.
// Assumes: inputs are already synchronous to clk. The history register
// resets to zero, so a pin held high through reset reads as a rise.
module pwr_edge_det #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Remember last sampled level of this pin.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pwr_timer.sv
// One-shot down-counter used for the fixed stop-grant delay and for the
// wake stabilization wait. A load arms it with CYCLES-1; expire is high
// while armed at zero and keep is high, so the owner sees expire exactly
// CYCLES edges after the loading edge. Dropping keep disarms it.
// Assumes: CYCLES >= 1; a load while armed is ignored.
module pwr_timer #(
    parameter int unsigned CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic keep,
    output logic expire
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Arm, count down, or disarm when the owner leaves the waiting state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load && !armed_q) begin
            cnt_q   <= LOAD_VAL;
            armed_q <= 1'b1;
        end else if (!keep) begin
            armed_q <= 1'b0;
        end else if (armed_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = armed_q && keep && (cnt_q == '0);
endmodule

// File: rtl/pwr_evt_latch.sv
// Pending break-event store: one sticky bit per event kind, set while the
// controller grants stop-clock, handed out as a single-cycle pulse in the
// first cycle back in Normal and cleared there.
// Assumes: capture and release are never high in the same cycle.
module pwr_evt_latch #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         release_now,
    input  logic         flush,
    input  logic [N-1:0] evt,
    output logic [N-1:0] deliver,
    output logic         any_pend
);
    logic [N-1:0] pend_q;

    // Collect events, drop them on flush or after they were delivered.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= '0;
        else if (flush)        pend_q <= '0;
        else if (release_now)  pend_q <= '0;
        else if (capture)      pend_q <= pend_q | evt;
    end

    assign deliver  = release_now ? pend_q : '0;
    assign any_pend = |pend_q;
endmodule

// File: rtl/pwr_state_fsm.sv
// Power-state sequencer. Holds the current state, the state a stop grant
// was requested from, which stop-grant flavour Sleep was entered from, and
// the sticky error flag. Timer expiries and pin edges come from siblings.
// Assumes: strobes last one cycle; request pins are synchronous levels.
module pwr_state_fsm
    import pwr_pkg::*;
#(
    parameter int unsigned NCORES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORES-1:0] core_halt,
    input  logic              ext_halt_en,
    input  logic              ext_stop_en,
    input  logic              stop_req,
    input  logic              sleep_req,
    input  logic              deep_req,
    input  logic              deeper_req,
    input  logic              sleep_rise,
    input  logic              deep_rise,
    input  logic              deeper_rise,
    input  logic              snoop_start,
    input  logic              snoop_done,
    input  logic              any_brk,
    input  logic              reinit_req,
    input  logic              any_pend,
    input  logic              sg_expire,
    input  logic              wake_expire,
    output pwr_state_e        cur,
    output pwr_state_e        nxt,
    output logic              err_q
);
    pwr_state_e origin_q;
    logic       sg_ext_q;
    logic       illegal;
    logic       all_halted;

    assign all_halted = &core_halt;

    // Detect pin sequences the platform must not produce.
    always_comb begin
        illegal = 1'b0;
        if (sleep_rise && !(cur == ST_SG || cur == ST_ESG)) illegal = 1'b1;
        if (deep_rise && cur != ST_SLEEP)                   illegal = 1'b1;
        if (deeper_rise && cur != ST_DEEP)                  illegal = 1'b1;
        if (snoop_start && in_sleep_fam(cur))               illegal = 1'b1;
    end

    // Next-state selection; re-init wins except inside a stop grant.
    always_comb begin
        nxt = cur;
        if (reinit_req && !in_sg_fam(cur)) begin
            nxt = ST_NORMAL;
        end else begin
            unique case (cur)
                ST_NORMAL: begin
                    if (stop_req)        nxt = ST_SG_PEND;
                    else if (all_halted) nxt = ext_halt_en ? ST_EHALT : ST_HALT;
                end
                ST_HALT, ST_EHALT: begin
                    if (any_brk)          nxt = ST_NORMAL;
                    else if (stop_req)    nxt = ST_SG_PEND;
                    else if (snoop_start) nxt = (cur == ST_HALT) ? ST_HALT_SNP : ST_EHALT_SNP;
                end
                ST_HALT_SNP:  if (snoop_done) nxt = ST_HALT;
                ST_EHALT_SNP: if (snoop_done) nxt = ST_EHALT;
                ST_SG_PEND: begin
                    if (!stop_req)      nxt = origin_q;
                    else if (sg_expire) nxt = ext_stop_en ? ST_ESG : ST_SG;
                end
                ST_SG, ST_ESG: begin
                    if (!stop_req)
                        nxt = (origin_q == ST_NORMAL || any_pend) ? ST_NORMAL : origin_q;
                    else if (sleep_rise)
                        nxt = ST_SLEEP;
                    else if (snoop_start)
                        nxt = (cur == ST_SG) ? ST_SG_SNP : ST_ESG_SNP;
                end
                ST_SG_SNP:  if (snoop_done) nxt = ST_SG;
                ST_ESG_SNP: if (snoop_done) nxt = ST_ESG;
                ST_SLEEP: begin
                    if (!sleep_req)     nxt = sg_ext_q ? ST_ESG : ST_SG;
                    else if (deep_rise) nxt = ST_DEEP;
                end
                ST_DEEP: begin
                    if (!deep_req)        nxt = ST_WAKE;
                    else if (deeper_rise) nxt = ST_DEEPER;
                end
                ST_DEEPER: if (!deeper_req) nxt = ST_DEEP;
                ST_WAKE:   if (wake_expire) nxt = ST_SLEEP;
                default:   nxt = ST_NORMAL;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_NORMAL;
        else        cur <= nxt;
    end

    // Remember where a stop request began, for the way back.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   origin_q <= ST_NORMAL;
        else if (nxt == ST_SG_PEND && cur != ST_SG_PEND) origin_q <= cur;
    end

    // Remember which stop-grant flavour was granted, for leaving Sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   sg_ext_q <= 1'b0;
        else if (cur == ST_SG_PEND && nxt == ST_ESG)  sg_ext_q <= 1'b1;
        else if (cur == ST_SG_PEND && nxt == ST_SG)   sg_ext_q <= 1'b0;
    end

    // Sticky error flag, cleared only by block reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (illegal) err_q <= 1'b1;
    end
endmodule

// File: rtl/pwr_state_ctrl.sv
// Top of the low-power state controller. Wires the pin edge detectors, the
// stop-grant delay and wake stabilization timers, the pending-event latch
// and the sequencer, and decodes the clock and request outputs from state.
// Assumes: all inputs synchronous to clk; STOP_DELAY and WAKE_CYCLES >= 1.
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned NCORES      = 2,
    parameter int unsigned STOP_DELAY  = 20,
    parameter int unsigned WAKE_CYCLES = 750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORES-1:0] core_halt,
    input  logic              ext_halt_en,
    input  logic              ext_stop_en,
    input  logic              stop_req,
    input  logic              sleep_req,
    input  logic              deep_req,
    input  logic              deeper_req,
    input  logic              snoop_start,
    input  logic              snoop_done,
    input  logic              brk_mgmt,
    input  logic              brk_init,
    input  logic              brk_nmi,
    input  logic              brk_intr,
    input  logic              reinit_req,
    input  logic              sg_ack_resp,
    output logic [3:0]        state_o,
    output logic              core_clk_en,
    output logic              bus_clk_may_stop,
    output logic              snoop_ok,
    output logic              low_op_req,
    output logic [3:0]        evt_deliver,
    output logic              err_flag
);
    localparam int unsigned NPIN = 3;

    pwr_state_e        cur, nxt;
    logic [NPIN-1:0]   pin_lvl, pin_rise;
    logic [NUM_BRK-1:0] brk_vec, dlv;
    logic              sg_expire, wake_expire, any_pend, err_q;

    assign pin_lvl = {deeper_req, deep_req, sleep_req};
    assign brk_vec = {brk_intr, brk_nmi, brk_init, brk_mgmt};

    pwr_edge_det #(.W(NPIN)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pin_lvl),
        .rise (pin_rise)
    );

    pwr_timer #(.CYCLES(STOP_DELAY)) u_sg_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cur == ST_SG_PEND && sg_ack_resp),
        .keep  (cur == ST_SG_PEND),
        .expire(sg_expire)
    );

    pwr_timer #(.CYCLES(WAKE_CYCLES)) u_wake_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cur != ST_WAKE && nxt == ST_WAKE),
        .keep  (cur == ST_WAKE),
        .expire(wake_expire)
    );

    pwr_evt_latch #(.N(NUM_BRK)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (in_sg_fam(cur)),
        .release_now(cur == ST_NORMAL),
        .flush      (reinit_req),
        .evt        (brk_vec),
        .deliver    (dlv),
        .any_pend   (any_pend)
    );

    pwr_state_fsm #(.NCORES(NCORES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_halt  (core_halt),
        .ext_halt_en(ext_halt_en),
        .ext_stop_en(ext_stop_en),
        .stop_req   (stop_req),
        .sleep_req  (sleep_req),
        .deep_req   (deep_req),
        .deeper_req (deeper_req),
        .sleep_rise (pin_rise[0]),
        .deep_rise  (pin_rise[1]),
        .deeper_rise(pin_rise[2]),
        .snoop_start(snoop_start),
        .snoop_done (snoop_done),
        .any_brk    (|brk_vec),
        .reinit_req (reinit_req),
        .any_pend   (any_pend),
        .sg_expire  (sg_expire),
        .wake_expire(wake_expire),
        .cur        (cur),
        .nxt        (nxt),
        .err_q      (err_q)
    );

    // Decode clock enables and requests from the current state.
    always_comb begin
        core_clk_en      = 1'b0;
        bus_clk_may_stop = 1'b0;
        low_op_req       = 1'b0;
        unique case (cur)
            ST_NORMAL, ST_SG_PEND, ST_HALT_SNP, ST_SG_SNP: core_clk_en = 1'b1;
            ST_EHALT_SNP, ST_ESG_SNP: begin
                core_clk_en = 1'b1;
                low_op_req  = 1'b1;
            end
            ST_EHALT, ST_ESG:    low_op_req       = 1'b1;
            ST_DEEP, ST_DEEPER:  bus_clk_may_stop = 1'b1;
            default: ;
        endcase
    end

    assign snoop_ok    = !in_sleep_fam(cur);
    assign state_o     = cur;
    assign evt_deliver = dlv;
    assign err_flag    = err_q;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
// Temporal checks on the controller's ports, bound into every instance.
// Assumes: state codes of pwr_pkg; STOP_DELAY fits in 16 bits.
module pwr_state_ctrl_chk
    import pwr_pkg::*;
#(
    parameter int unsigned STOP_DELAY = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] state_o,
    input logic       snoop_start,
    input logic       snoop_done,
    input logic       reinit_req,
    input logic       sg_ack_resp,
    input logic       core_clk_en,
    input logic       bus_clk_may_stop,
    input logic [3:0] evt_deliver,
    input logic       err_flag
);
    logic [15:0] since_ack;
    logic        ack_seen;
    logic        sleepy;

    assign sleepy = state_o >= 4'd10 && state_o <= 4'd13;

    // Count edges since the acknowledge strobe while waiting for stop grant.
    always_ff @(posedge clk) begin
        if (!rst_n || state_o != ST_SG_PEND) begin
            since_ack <= '0;
            ack_seen  <= 1'b0;
        end else if (!ack_seen && sg_ack_resp) begin
            since_ack <= '0;
            ack_seen  <= 1'b1;
        end else if (ack_seen) begin
            since_ack <= since_ack + 1'b1;
        end
    end

    a_r4_grant_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o inside {ST_SG, ST_ESG} && $past(state_o) == ST_SG_PEND)
        |-> since_ack == 16'(STOP_DELAY))
        else $error("stop grant entered after wrong delay");

    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag)
        else $error("error flag cleared");

    a_r12_sleep_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (sleepy && snoop_start && !reinit_req) |=> (err_flag && $stable(state_o)))
        else $error("snoop in sleep not flagged");

    a_r8_snoop_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SG_SNP && snoop_done) |=> state_o == ST_SG)
        else $error("snoop did not return to stop grant");

    a_r6_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_deliver != 4'd0) |=> evt_deliver == 4'd0)
        else $error("event delivered twice");

    a_r11_reinit_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (sleepy && reinit_req) |=> state_o == ST_NORMAL)
        else $error("reinit from sleep not direct");

    a_r13_clk_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk_may_stop |-> !core_clk_en)
        else $error("core clock on while bus clock may stop");
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.STOP_DELAY(STOP_DELAY)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .state_o         (state_o),
    .snoop_start     (snoop_start),
    .snoop_done      (snoop_done),
    .reinit_req      (reinit_req),
    .sg_ack_resp     (sg_ack_resp),
    .core_clk_en     (core_clk_en),
    .bus_clk_may_stop(bus_clk_may_stop),
    .evt_deliver     (evt_deliver),
    .err_flag        (err_flag)
);

// File: tb/sim_pwr_state_ctrl.sv
module sim_pwr_state_ctrl;
    localparam int SGD  = 20;
    localparam int WAKE = 750;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] core_halt = '0;
    logic ext_halt_en = 0, ext_stop_en = 0, stop_req = 0, sleep_req = 0;
    logic deep_req = 0, deeper_req = 0, snoop_start = 0, snoop_done = 0;
    logic brk_mgmt = 0, brk_init = 0, brk_nmi = 0, brk_intr = 0;
    logic reinit_req = 0, sg_ack_resp = 0;
    logic [3:0] state_o, evt_deliver;
    logic core_clk_en, bus_clk_may_stop, snoop_ok, low_op_req, err_flag;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_state_ctrl u0 (.*);

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(int act, int exp, string req);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; stop_req = 0; sleep_req = 0; deep_req = 0; deeper_req = 0;
        core_halt = 0; ext_halt_en = 0; ext_stop_en = 0;
        step(2);
        rst_n = 1;
        step(1);
    endtask

    // Raise stop_req, give the acknowledge, wait the fixed delay.
    task automatic enter_sg();
        stop_req = 1; step(1);
        chk(state_o, 5, "R4 wait state");
        sg_ack_resp = 1; step(1); sg_ack_resp = 0;
        step(SGD - 1);
        chk(state_o, 5, "R4 still waiting one before delay");
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk(state_o, 0, "R1 state");
        chk(core_clk_en, 1, "R1 core clock");
        chk(bus_clk_may_stop, 0, "R1 bus clock");
        chk(err_flag, 0, "R1 error");
        chk(evt_deliver, 0, "R1 events");
    endtask

    task automatic t_halt();
        do_reset();
        core_halt = 2'b01; step(2);
        chk(state_o, 0, "R2 partial halt stays Normal");
        core_halt = 2'b11; step(1);
        chk(state_o, 1, "R2 HALT");
        chk(core_clk_en, 0, "R13 clock off in HALT");
        core_halt = 0; brk_intr = 1; step(1); brk_intr = 0;
        chk(state_o, 0, "R3 intr wakes");
        ext_halt_en = 1; core_halt = 2'b11; step(1);
        chk(state_o, 2, "R2 Extended HALT");
        chk(low_op_req, 1, "R13 low op in ext halt");
        core_halt = 0; brk_nmi = 1; step(1); brk_nmi = 0;
        chk(state_o, 0, "R3 nmi wakes");
        chk(low_op_req, 0, "R13 low op off in Normal");
    endtask

    task automatic t_stop_normal();
        do_reset();
        stop_req = 1; step(3);
        stop_req = 0; step(1);
        chk(state_o, 0, "R4 abort before ack");
        enter_sg();
        chk(state_o, 6, "R4 Stop Grant after delay");
        chk(core_clk_en, 0, "R13 clock off in SG");
        chk(snoop_ok, 1, "R13 snoop ok in SG");
        brk_mgmt = 1; step(1); brk_mgmt = 0;
        brk_init = 1; step(1); brk_init = 0;
        brk_mgmt = 1; step(1); brk_mgmt = 0;
        chk(state_o, 6, "R6 events do not wake SG");
        stop_req = 0; step(1);
        chk(state_o, 0, "R5 back to Normal");
        chk(evt_deliver, 3, "R6 pending delivered once each");
        step(1);
        chk(evt_deliver, 0, "R6 pulse one cycle");
        enter_sg();
        brk_intr = 1; step(1); brk_intr = 0;
        reinit_req = 1; step(1); reinit_req = 0;
        chk(state_o, 6, "R7 reinit keeps SG");
        stop_req = 0; step(1);
        chk(evt_deliver, 0, "R7 reinit flushed pending");
    endtask

    task automatic t_stop_halt();
        do_reset();
        ext_stop_en = 1; core_halt = 2'b11; step(1);
        chk(state_o, 1, "R2 HALT before stop");
        enter_sg();
        chk(state_o, 7, "R4 Extended Stop Grant");
        chk(low_op_req, 1, "R13 low op in ESG");
        stop_req = 0; step(1);
        chk(state_o, 1, "R5 back to HALT");
        enter_sg();
        brk_nmi = 1; step(1); brk_nmi = 0;
        core_halt = 0; stop_req = 0; step(1);
        chk(state_o, 0, "R5 pending forces Normal");
        chk(evt_deliver, 4, "R6 nmi delivered");
    endtask

    task automatic t_snoop();
        do_reset();
        core_halt = 2'b11; step(1);
        snoop_start = 1; step(1); snoop_start = 0;
        chk(state_o, 3, "R8 HALT snoop");
        chk(core_clk_en, 1, "R13 clock on in snoop");
        snoop_done = 1; step(1); snoop_done = 0;
        chk(state_o, 1, "R8 back to HALT");
        core_halt = 0; brk_init = 1; step(1); brk_init = 0;
        ext_halt_en = 1; core_halt = 2'b11; step(1);
        snoop_start = 1; step(1); snoop_start = 0;
        chk(state_o, 4, "R8 ext HALT snoop");
        snoop_done = 1; step(1); snoop_done = 0;
        chk(state_o, 2, "R8 back to ext HALT");
        core_halt = 0; brk_init = 1; step(1); brk_init = 0;
        enter_sg();
        snoop_start = 1; step(1); snoop_start = 0;
        chk(state_o, 8, "R8 SG snoop");
        snoop_done = 1; step(1); snoop_done = 0;
        chk(state_o, 6, "R8 back to SG");
        chk(err_flag, 0, "R12 no error on legal snoops");
    endtask

    task automatic t_sleep();
        do_reset();
        enter_sg();
        sleep_req = 1; step(1);
        chk(state_o, 10, "R9 Sleep");
        chk(snoop_ok, 0, "R13 no snoops in Sleep");
        brk_intr = 1; step(1); brk_intr = 0;
        chk(state_o, 10, "R11 intr ignored in Sleep");
        deep_req = 1; step(1);
        chk(state_o, 12, "R9 Deep Sleep");
        chk(bus_clk_may_stop, 1, "R13 bus clock may stop");
        deeper_req = 1; step(1);
        chk(state_o, 13, "R9 Deeper Sleep");
        deeper_req = 0; step(1);
        chk(state_o, 12, "R9 back to Deep");
        deep_req = 0; step(1);
        chk(state_o, 11, "R10 stabilizing");
        step(WAKE - 1);
        chk(state_o, 11, "R10 still stabilizing at last cycle");
        step(1);
        chk(state_o, 10, "R10 Sleep after wait");
        sleep_req = 0; step(1);
        chk(state_o, 6, "R9 back to Stop Grant");
        stop_req = 0; step(1);
        chk(evt_deliver, 0, "R11 sleep events not latched");
        chk(err_flag, 0, "R12 legal chain no error");
    endtask

    task automatic t_illegal();
        do_reset();
        sleep_req = 1; step(1);
        chk(state_o, 0, "R12 state kept on illegal sleep");
        chk(err_flag, 1, "R12 illegal sleep flagged");
        sleep_req = 0; step(3);
        chk(err_flag, 1, "R12 sticky");
        do_reset();
        enter_sg();
        deep_req = 1; step(1);
        chk(state_o, 6, "R12 state kept on illegal deep");
        chk(err_flag, 1, "R12 illegal deep flagged");
        deep_req = 0;
        do_reset();
        enter_sg();
        sleep_req = 1; step(1);
        snoop_start = 1; step(1); snoop_start = 0;
        chk(state_o, 10, "R12 snoop in sleep keeps state");
        chk(err_flag, 1, "R12 snoop in sleep flagged");
        reinit_req = 1; step(1); reinit_req = 0; sleep_req = 0; stop_req = 0;
        chk(state_o, 0, "R11 reinit from Sleep to Normal");
        core_halt = 2'b11; step(1);
        reinit_req = 1; step(1); reinit_req = 0; core_halt = 0;
        chk(state_o, 0, "R7 reinit from HALT to Normal");
    endtask

    initial begin
        t_reset();
        t_halt();
        t_stop_normal();
        t_stop_halt();
        t_snoop();
        t_sleep();
        t_illegal();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule